// File: doc/BRIEF.md
# Multi-Pass Accumulation Buffer with Post-Convolution Unit

This block sits under the bottom edge of a convolution compute array. Each cycle the array may present one vector of signed 18-bit partial sums, one lane per output channel. Every vector belongs to one spatial position of the current output tile. The block keeps a running total for every position in an on-chip accumulation memory. Its capacity in bytes is a parameter, 32 KB by default. The same tile is streamed several times, once for each group of input channels, and each pass adds into the stored totals.

When the last configured pass has been accumulated, the block drains the memory. It applies one post-convolution operation chosen for the layer: pass-through, rectification, 2x2 maximum pooling or 2x2 average pooling. It then requantises each lane to a signed byte and presents the result on a valid/ready output stream. The layer settings come from configuration inputs that a memory-mapped register bank drives. They are captured when a start pulse arrives. A busy flag covers the whole job.

Top module: `acc_postop_buf`

## Requirements
- R1: Out of reset `busy` is 0 and `out_valid` is 0.
- R2: A `start` pulse while idle captures `cfg_op`, `cfg_passes`, `cfg_rows`, `cfg_cols` and `cfg_shift` and raises `busy` on the next cycle. A `start` while busy has no effect, and later changes to the cfg inputs do not alter the running job.
- R3: A tile has `cfg_rows`×`cfg_cols` positions, streamed in row-major order once per pass. There are `cfg_passes` passes, and a value of 0 counts as 1. The first pass stores the incoming lane value and discards the old contents. Each later pass adds to the stored value, wrapping modulo 2^18 in two's complement. Lane i occupies `psum_data` bits [18i+17:18i].
- R4: Two updates of the same position on consecutive cycles (a 1x1 tile) both take effect. No pass is lost.
- R5: `psum_valid` is ignored while idle and while the block is draining results.
- R6: With `cfg_op`=0 (pass-through), one output word is emitted per position, in row-major order.
- R7: With `cfg_op`=1 (rectify), negative totals become 0 before requantisation.
- R8: With `cfg_op`=2, each output is the lane-wise maximum over a 2x2 window with stride 2. There are (rows/2)×(cols/2) outputs, with windows taken in row-major order. Rows and cols are even.
- R9: With `cfg_op`=3, each output is the sum of the 2x2 window shifted arithmetically right by 2, which rounds toward minus infinity.
- R10: Each lane result is shifted arithmetically right by `cfg_shift` and clamped to [-128, 127]. Lane i appears on `out_data` bits [8i+7:8i].
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable.
- R12: `busy` stays high until the last output word is accepted and is low on the cycle after that acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job with the current cfg inputs |
| cfg_op | input | 2 | Post-operation: 0 pass, 1 rectify, 2 max pool, 3 average pool |
| cfg_passes | input | PASS_W | Number of accumulation passes (0 means 1) |
| cfg_rows | input | DIM_W | Tile rows |
| cfg_cols | input | DIM_W | Tile columns |
| cfg_shift | input | SHIFT_W | Requantisation right shift |
| busy | output | 1 | Job in progress |
| psum_valid | input | 1 | Partial-sum vector present |
| psum_data | input | LANES*18 | Partial-sum lanes |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Downstream accepts result |
| out_data | output | LANES*8 | Requantised result lanes |

## Verification
The bench drives a single-position tile over five back-to-back passes. A read-modify-write pipeline without a bypass would return stale memory and drop passes, so the totals would come out too small. Large-scale stimulus forces both wrap-around of the 18-bit totals and clamping at both ends of the byte range, which would expose a wrong sign extension or a missing clamp. Average pooling is fed negative sums, so a logical shift or a round-toward-zero would produce off-by-one or huge values. Stray partial sums during drain, a second start mid-job with scrambled configuration, and random output back-pressure would each corrupt totals, change the operation or drop and duplicate words in a faulty design.

// File: rtl/accpo_pkg.sv
package accpo_pkg;

    localparam int ACC_W = 18;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_RELU = 2'd1,
        OP_MAX  = 2'd2,
        OP_AVG  = 2'd3
    } postop_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ACC   = 3'd1,
        ST_FLUSH = 3'd2,
        ST_RD    = 3'd3,
        ST_WAIT  = 3'd4,
        ST_EMIT  = 3'd5
    } accpo_state_e;

endpackage

// File: rtl/accpo_mem.sv
module accpo_mem #(
    parameter int DEPTH  = 64,
    parameter int AW     = 6,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store [DEPTH];

    // synchronous read, read-before-write on a shared address
    always_ff @(posedge clk) begin
        rdata <= store[raddr];
        if (we) begin
            store[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/accpo_adder.sv
module accpo_adder #(
    parameter int LANES = 2,
    parameter int ACC_W = 18
) (
    input  logic                   first,
    input  logic [LANES*ACC_W-1:0] base,
    input  logic [LANES*ACC_W-1:0] incr,
    output logic [LANES*ACC_W-1:0] sum
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ACC_W-1:0] b_l;
        logic [ACC_W-1:0] i_l;
        assign b_l = base[i*ACC_W +: ACC_W];
        assign i_l = incr[i*ACC_W +: ACC_W];
        // modulo 2^ACC_W wrap is intended
        assign sum[i*ACC_W +: ACC_W] = first ? i_l : (b_l + i_l);
    end

endmodule

// File: rtl/accpo_reduce.sv
module accpo_reduce
    import accpo_pkg::*;
#(
    parameter int LANES = 2,
    parameter int AW_IN = 18,
    parameter int RED_W = 20
) (
    input  postop_e                op,
    input  logic                   first,
    input  logic [LANES*RED_W-1:0] red_in,
    input  logic [LANES*AW_IN-1:0] val,
    output logic [LANES*RED_W-1:0] red_out
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [RED_W-1:0] v_l;
        logic signed [RED_W-1:0] r_l;
        logic signed [RED_W-1:0] mx_l;
        logic signed [RED_W-1:0] sm_l;
        assign v_l  = {{(RED_W-AW_IN){val[i*AW_IN+AW_IN-1]}}, val[i*AW_IN +: AW_IN]};
        assign r_l  = red_in[i*RED_W +: RED_W];
        assign mx_l = (v_l > r_l) ? v_l : r_l;
        assign sm_l = r_l + v_l;
        assign red_out[i*RED_W +: RED_W] = first           ? v_l  :
                                           (op == OP_MAX)  ? mx_l :
                                           (op == OP_AVG)  ? sm_l : v_l;
    end

endmodule

// File: rtl/accpo_requant.sv
module accpo_requant
    import accpo_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int RED_W   = 20,
    parameter int SHIFT_W = 4
) (
    input  postop_e                op,
    input  logic [SHIFT_W-1:0]     shift,
    input  logic [LANES*RED_W-1:0] red,
    output logic [LANES*8-1:0]     q
);

    localparam logic signed [RED_W-1:0] SAT_HI = RED_W'(127);
    localparam logic signed [RED_W-1:0] SAT_LO = -RED_W'(128);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [RED_W-1:0] r_l;
        logic signed [RED_W-1:0] a_l;
        logic signed [RED_W-1:0] z_l;
        logic signed [RED_W-1:0] s_l;
        assign r_l = red[i*RED_W +: RED_W];
        assign a_l = (op == OP_AVG) ? (r_l >>> 2) : r_l;
        assign z_l = ((op == OP_RELU) && a_l[RED_W-1]) ? '0 : a_l;
        assign s_l = z_l >>> shift;
        assign q[i*8 +: 8] = (s_l > SAT_HI) ? 8'h7f :
                             (s_l < SAT_LO) ? 8'h80 : s_l[7:0];
    end

endmodule

// File: rtl/acc_postop_buf.sv
module acc_postop_buf
    import accpo_pkg::*;
#(
    parameter int LANES     = 16,
    parameter int ACC_BYTES = 32768,
    parameter int DIM_W     = 5,
    parameter int PASS_W    = 8,
    parameter int SHIFT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               cfg_op,
    input  logic [PASS_W-1:0]        cfg_passes,
    input  logic [DIM_W-1:0]         cfg_rows,
    input  logic [DIM_W-1:0]         cfg_cols,
    input  logic [SHIFT_W-1:0]       cfg_shift,
    output logic                     busy,
    input  logic                     psum_valid,
    input  logic [LANES*ACC_W-1:0]   psum_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [LANES*8-1:0]       out_data
);

    localparam int WORD_W = LANES * ACC_W;
    localparam int DEPTH  = (ACC_BYTES * 8) / WORD_W;
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW     = 2 * DIM_W;
    localparam int RED_W  = ACC_W + 2;
    localparam int OUT_W  = LANES * 8;

    typedef struct packed {
        accpo_state_e              st;
        postop_e                   op;
        logic [PASS_W-1:0]         passes;
        logic [SHIFT_W-1:0]        shift;
        logic [DIM_W-1:0]          rows;
        logic [DIM_W-1:0]          cols;
        logic [PASS_W-1:0]         pass_cnt;
        logic [AW-1:0]             acc_pos;
        logic [DIM_W-1:0]          orow;
        logic [DIM_W-1:0]          ocol;
        logic [1:0]                k;
        logic                      s1_vld;
        logic                      s1_first;
        logic [AW-1:0]             s1_pos;
        logic [WORD_W-1:0]         s1_data;
        logic                      fwd;
        logic [WORD_W-1:0]         fwd_data;
        logic [LANES*RED_W-1:0]    red;
    } regs_t;

    regs_t q, d;

    // shared datapath wires
    logic                   accept;
    logic                   pool;
    logic [PW-1:0]          tile_last;
    logic [PASS_W-1:0]      pass_last;
    logic [DIM_W-1:0]       ocol_last;
    logic [DIM_W-1:0]       orow_last;
    logic [1:0]             k_last;
    logic [DIM_W:0]         rd_row;
    logic [DIM_W:0]         rd_col;
    logic [AW-1:0]          drain_addr;
    logic [AW-1:0]          mem_raddr;
    logic [WORD_W-1:0]      mem_rdata;
    logic [WORD_W-1:0]      old_vec;
    logic [WORD_W-1:0]      sum_vec;
    logic                   mem_we;
    logic [LANES*RED_W-1:0] red_nxt;

    assign accept    = (q.st == ST_ACC) && psum_valid;
    assign pool      = (q.op == OP_MAX) || (q.op == OP_AVG);
    assign tile_last = PW'(q.rows) * PW'(q.cols) - PW'(1);
    assign pass_last = (q.passes == '0) ? '0 : (q.passes - PASS_W'(1));
    assign ocol_last = (pool ? (q.cols >> 1) : q.cols) - DIM_W'(1);
    assign orow_last = (pool ? (q.rows >> 1) : q.rows) - DIM_W'(1);
    assign k_last    = pool ? 2'd3 : 2'd0;

    assign rd_row = pool ? {q.orow, q.k[1]} : {1'b0, q.orow};
    assign rd_col = pool ? {q.ocol, q.k[0]} : {1'b0, q.ocol};
    assign drain_addr = AW'(PW'(rd_row) * PW'(q.cols) + PW'(rd_col));
    assign mem_raddr  = (q.st == ST_ACC) ? q.acc_pos : drain_addr;

    // bypass: the write of the previous cycle is not yet visible in memory
    assign old_vec = q.fwd ? q.fwd_data : mem_rdata;
    assign mem_we  = q.s1_vld;

    accpo_mem #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .WORD_W(WORD_W)
    ) mem_i (
        .clk  (clk),
        .we   (mem_we),
        .waddr(q.s1_pos),
        .wdata(sum_vec),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    accpo_adder #(
        .LANES(LANES),
        .ACC_W(ACC_W)
    ) add_i (
        .first(q.s1_first),
        .base (old_vec),
        .incr (q.s1_data),
        .sum  (sum_vec)
    );

    accpo_reduce #(
        .LANES(LANES),
        .AW_IN(ACC_W),
        .RED_W(RED_W)
    ) red_i (
        .op     (q.op),
        .first  (q.k == 2'd0),
        .red_in (q.red),
        .val    (mem_rdata),
        .red_out(red_nxt)
    );

    accpo_requant #(
        .LANES  (LANES),
        .RED_W  (RED_W),
        .SHIFT_W(SHIFT_W)
    ) rq_i (
        .op   (q.op),
        .shift(q.shift),
        .red  (q.red),
        .q    (out_data)
    );

    always_comb begin
        d = q;
        d.s1_vld   = accept;
        d.s1_first = (q.pass_cnt == '0);
        d.s1_pos   = q.acc_pos;
        d.s1_data  = psum_data;
        d.fwd      = accept && q.s1_vld && (q.s1_pos == q.acc_pos);
        d.fwd_data = sum_vec;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st       = ST_ACC;
                    d.op       = postop_e'(cfg_op);
                    d.passes   = cfg_passes;
                    d.rows     = cfg_rows;
                    d.cols     = cfg_cols;
                    d.shift    = cfg_shift;
                    d.pass_cnt = '0;
                    d.acc_pos  = '0;
                end
            end
            ST_ACC: begin
                if (accept) begin
                    if (PW'(q.acc_pos) == tile_last) begin
                        d.acc_pos = '0;
                        if (q.pass_cnt == pass_last) begin
                            d.st = ST_FLUSH;
                        end else begin
                            d.pass_cnt = q.pass_cnt + PASS_W'(1);
                        end
                    end else begin
                        d.acc_pos = q.acc_pos + AW'(1);
                    end
                end
            end
            ST_FLUSH: begin
                d.st   = ST_RD;
                d.orow = '0;
                d.ocol = '0;
                d.k    = '0;
            end
            ST_RD: begin
                d.st = ST_WAIT;
            end
            ST_WAIT: begin
                d.red = red_nxt;
                if (q.k == k_last) begin
                    d.k  = '0;
                    d.st = ST_EMIT;
                end else begin
                    d.k  = q.k + 2'd1;
                    d.st = ST_RD;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    d.st = ST_RD;
                    if (q.ocol == ocol_last) begin
                        d.ocol = '0;
                        if (q.orow == orow_last) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.orow = q.orow + DIM_W'(1);
                        end
                    end else begin
                        d.ocol = q.ocol + DIM_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign out_valid = (q.st == ST_EMIT);

endmodule

// File: rtl/accpo_checker.sv
module accpo_checker #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             mem_we
);

    p_hold_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_valid_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    p_busy_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(out_valid && out_ready));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_idle_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

endmodule

bind acc_postop_buf accpo_checker #(.OUT_W(OUT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .mem_we   (mem_we)
);

// File: tb/acc_postop_buf_tb_top.sv
module acc_postop_buf_tb_top;

    localparam int LANES     = 2;
    localparam int ACC_BYTES = 288;
    localparam int DIM_W     = 4;
    localparam int PASS_W    = 4;
    localparam int SHIFT_W   = 4;
    localparam int AW18      = 18;
    localparam int OUT_W     = LANES * 8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start = 1'b0;
    logic [1:0]               cfg_op = '0;
    logic [PASS_W-1:0]        cfg_passes = '0;
    logic [DIM_W-1:0]         cfg_rows = '0;
    logic [DIM_W-1:0]         cfg_cols = '0;
    logic [SHIFT_W-1:0]       cfg_shift = '0;
    logic                     busy;
    logic                     psum_valid = 1'b0;
    logic [LANES*AW18-1:0]    psum_data = '0;
    logic                     out_valid;
    logic                     out_ready = 1'b1;
    logic [OUT_W-1:0]         out_data;

    always #4 clk = ~clk;

    acc_postop_buf #(
        .LANES    (LANES),
        .ACC_BYTES(ACC_BYTES),
        .DIM_W    (DIM_W),
        .PASS_W   (PASS_W),
        .SHIFT_W  (SHIFT_W)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_op    (cfg_op),
        .cfg_passes(cfg_passes),
        .cfg_rows  (cfg_rows),
        .cfg_cols  (cfg_cols),
        .cfg_shift (cfg_shift),
        .busy      (busy),
        .psum_valid(psum_valid),
        .psum_data (psum_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          acc_m [64][LANES];
    logic [OUT_W-1:0] exp_q [$];
    string       tag_q [$];
    bit          ready_rand = 1'b0;
    logic [15:0] lfsr = 16'hace1;
    bit          hold_pend = 1'b0;
    logic [OUT_W-1:0] hold_data = '0;
    bit          idle_pend = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int wrap18(input int x);
        int w;
        w = x & 32'h3ffff;
        if (w >= 131072) w = w - 262144;
        return w;
    endfunction

    function automatic int sat8(input int x);
        if (x > 127) return 127;
        if (x < -128) return -128;
        return x;
    endfunction

    function automatic int gen(input int seed, input int p, input int pos, input int l, input int scale);
        return (((seed * 13 + p * 37 + pos * 11 + l * 29) % 201) - 100) * scale;
    endfunction

    // output ready pattern, changed just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = ready_rand ? lfsr[0] : 1'b1;
        end
    end

    // monitor: scoreboard pop and compare, mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend) begin
                check(out_valid && (out_data == hold_data), "R11 hold", longint'(out_data), longint'(hold_data));
                hold_pend = 1'b0;
            end
            if (idle_pend) begin
                check(!busy, "R12 busy after last word", longint'(busy), 0);
                idle_pend = 1'b0;
            end
            if (out_valid) begin
                if (out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6 unexpected word", longint'(out_data), 0);
                    end else begin
                        logic [OUT_W-1:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_data == e, t, longint'(out_data), longint'(e));
                        check(busy, "R12 busy during output", longint'(busy), 1);
                        if (exp_q.size() == 0) idle_pend = 1'b1;
                    end
                end else begin
                    hold_pend = 1'b1;
                    hold_data = out_data;
                end
            end
        end
    end

    task automatic run_tile(input int op, input int passes, input int rows, input int cols,
                            input int shift, input int seed, input int scale,
                            input bit gaps, input bit restart, input string tag);
        int np;
        np = (passes == 0) ? 1 : passes;
        @(posedge clk); #1;
        cfg_op = op[1:0]; cfg_passes = passes[PASS_W-1:0];
        cfg_rows = rows[DIM_W-1:0]; cfg_cols = cols[DIM_W-1:0]; cfg_shift = shift[SHIFT_W-1:0];
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        check(busy, "R2 busy after start", longint'(busy), 1);
        // scramble cfg: the running job must keep its captured settings (R2)
        cfg_op = 2'(op + 1); cfg_shift = 4'(shift + 3); cfg_rows = 4'(rows + 1);
        for (int p = 0; p < np; p++) begin
            for (int pos = 0; pos < rows * cols; pos++) begin
                for (int l = 0; l < LANES; l++) begin
                    int v;
                    v = gen(seed, p, pos, l, scale);
                    acc_m[pos][l] = (p == 0) ? wrap18(v) : wrap18(acc_m[pos][l] + v);
                    psum_data[l*AW18 +: AW18] = v[17:0];
                end
                psum_valid = 1'b1;
                start = (restart && p == 0 && pos == 1);
                @(posedge clk); #1;
                start = 1'b0;
                if (gaps && (pos % 3 == 1)) begin
                    psum_valid = 1'b0;
                    @(posedge clk); #1;
                end
            end
        end
        psum_valid = 1'b0;
        // expected results
        if (op < 2) begin
            for (int r = 0; r < rows; r++) begin
                for (int c = 0; c < cols; c++) begin
                    logic [OUT_W-1:0] w;
                    for (int l = 0; l < LANES; l++) begin
                        int v;
                        v = acc_m[r*cols + c][l];
                        if (op == 1 && v < 0) v = 0;
                        v = sat8(v >>> shift);
                        w[l*8 +: 8] = v[7:0];
                    end
                    exp_q.push_back(w);
                    tag_q.push_back(tag);
                end
            end
        end else begin
            for (int r = 0; r < rows / 2; r++) begin
                for (int c = 0; c < cols / 2; c++) begin
                    logic [OUT_W-1:0] w;
                    for (int l = 0; l < LANES; l++) begin
                        int a0, a1, a2, a3, v;
                        a0 = acc_m[(2*r)*cols + 2*c][l];
                        a1 = acc_m[(2*r)*cols + 2*c + 1][l];
                        a2 = acc_m[(2*r+1)*cols + 2*c][l];
                        a3 = acc_m[(2*r+1)*cols + 2*c + 1][l];
                        if (op == 2) begin
                            v = a0;
                            if (a1 > v) v = a1;
                            if (a2 > v) v = a2;
                            if (a3 > v) v = a3;
                        end else begin
                            v = (a0 + a1 + a2 + a3) >>> 2;
                        end
                        v = sat8(v >>> shift);
                        w[l*8 +: 8] = v[7:0];
                    end
                    exp_q.push_back(w);
                    tag_q.push_back(tag);
                end
            end
        end
        // stray partial sums while draining (R5)
        for (int i = 0; i < 6; i++) begin
            psum_valid = 1'b1;
            psum_data = {LANES{18'h1_5555}};
            @(posedge clk); #1;
        end
        psum_valid = 1'b0;
        while (busy) begin
            @(posedge clk); #1;
        end
        @(negedge clk);
        check(exp_q.size() == 0, "R12 all words out before idle", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog actual=hung expected=idle");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy, "R1 busy in reset", longint'(busy), 0);
        check(!out_valid, "R1 out_valid in reset", longint'(out_valid), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R1 busy after reset", longint'(busy), 0);
        check(!out_valid, "R1 out_valid after reset", longint'(out_valid), 0);

        // R5: partial sums while idle are dropped
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            psum_valid = 1'b1;
            psum_data = {LANES{18'h2_0001}};
        end
        @(posedge clk); #1;
        psum_valid = 1'b0;
        @(negedge clk);
        check(!busy && !out_valid, "R5 idle psum ignored", longint'({busy, out_valid}), 0);

        // R3 R6 R10: pass-through, 3 passes, with input gaps
        run_tile(0, 3, 3, 4, 2, 1, 40, 1'b1, 1'b0, "R3/R6/R10 identity");
        // R7 R2: rectify, back-pressure, start during job
        ready_rand = 1'b1;
        run_tile(1, 2, 2, 2, 0, 2, 1, 1'b0, 1'b1, "R7/R2 relu");
        // R8: max pool
        run_tile(2, 2, 4, 4, 1, 3, 3, 1'b1, 1'b0, "R8 maxpool");
        // R9 R3: average pool, passes field 0 means one pass
        run_tile(3, 0, 4, 4, 0, 4, 1, 1'b0, 1'b0, "R9/R3 avgpool");
        // R4: single position, back-to-back passes through the bypass
        ready_rand = 1'b0;
        run_tile(0, 5, 1, 1, 4, 5, 7, 1'b0, 1'b0, "R4 back-to-back");
        // R10 R3: saturation both ways and 18-bit wrap
        run_tile(0, 3, 2, 3, 0, 6, 1200, 1'b0, 1'b0, "R10/R3 saturate wrap");
        ready_rand = 1'b1;
        run_tile(3, 2, 2, 4, 3, 7, 900, 1'b0, 1'b0, "R9/R10 avg large");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule